// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept. It watches the byte stream of a frame that is being received. It captures the first six bytes as the destination address and runs a CRC-32 over them to form a 6-bit multicast hash index. When the frame ends, it combines several checks into one accept/reject verdict:

- the address rules (exact station match, promiscuous, broadcast, hashed multicast);
- a minimum-length rule;
- the error flags that arrive with the end-of-frame strobe.

Next to the verdict it reports:

- whether the destination was a group (multicast or broadcast) address;
- whether the frame should actually be written to memory, which is not the case in monitor mode.

A separate feature lets a remote station control the local transmitter. It works only when the automatic-transmit-off enable is set. A multicast frame whose hash lands in the second-highest bin turns the transmitter off. One that lands in the highest bin turns it back on. The receive logic that frames the bytes, and the storage of the frame, lie outside this block.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `decision_valid` and `frame_accept` are 0 and `tx_enable` is 1.
- R2: The outputs change only at frame boundaries.
  - `decision_valid` rises in the cycle after `frm_end`.
  - The verdict outputs hold their values until the next `frm_start`.
  - `decision_valid` returns to 0 in the cycle after `frm_start`.
- R3: A frame with fewer than 64 data bytes is rejected unless `rx_cfg[1]` (runt accept) is set. A frame with fewer than 6 bytes is always rejected.
- R4: A frame ending with `frm_crc_err` or `frm_align_err` high is rejected unless `rx_cfg[0]` (keep errored) is set.
- R5: A unicast destination is accepted when it equals `station_addr`, or for any value when `rx_cfg[4]` (promiscuous) is set.
  - The first received byte sits in `station_addr[7:0]`.
  - Bit 0 of that byte is the group bit.
- R6: The all-ones destination is accepted only when `rx_cfg[2]` (broadcast accept) is set.
- R7: A multicast destination is accepted only when `rx_cfg[3]` is set and `mcast_hash[idx]` is 1.
  - `idx` is bits [31:26] of a reflected CRC-32 (polynomial 0xEDB88320, seed all ones, LSB first, no final inversion) taken over the six destination bytes.
  - Register `idx[5:3]` maps to `mcast_hash[8*k+7:8*k]`, and `idx[2:0]` picks the bit within it.
- R8: `frame_group` is 0 for an accepted frame addressed to a physical address and 1 for one accepted on a multicast or broadcast address.
- R9: `frame_store` equals `frame_accept` with `rx_cfg[5]` (monitor) clear, and is 0 with it set.
- R10: `tx_enable` is controlled by completed non-broadcast multicast frames, whatever their acceptance or error flags.
  - With `auto_tx_off_en` set, a frame hashing to bin 62 clears `tx_enable` and a frame hashing to bin 63 sets it, in the cycle after `frm_end`.
  - With `auto_tx_off_en` clear, or for any other frame, `tx_enable` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_cfg | input | 6 | Receive configuration bits |
| station_addr | input | 48 | Station address, first wire byte in [7:0] |
| mcast_hash | input | 64 | Multicast hash table, eight byte registers |
| auto_tx_off_en | input | 1 | Enables remote transmitter on/off by hash bins 62/63 |
| frm_start | input | 1 | One-cycle strobe before the first byte of a frame |
| byte_valid | input | 1 | `byte_data` holds a frame byte this cycle |
| byte_data | input | 8 | Received frame byte |
| frm_end | input | 1 | One-cycle strobe after the last byte |
| frm_crc_err | input | 1 | CRC error flag, valid with `frm_end` |
| frm_align_err | input | 1 | Alignment error flag, valid with `frm_end` |
| decision_valid | output | 1 | Verdict outputs are valid |
| frame_accept | output | 1 | Frame passes all filter rules |
| frame_group | output | 1 | Destination is a group address |
| frame_store | output | 1 | Frame should be written to memory |
| tx_enable | output | 1 | Transmitter permitted |

## Verification
The in-line assertions watch the timing behaviour on every cycle:

- the verdict appears after an end strobe and is cleared after a start strobe;
- the verdict holds steady in between;
- the store flag never rises without acceptance;
- the byte counter only climbs within a frame;
- the CRC reseeds at each frame;
- the transmitter enable moves only after a frame end.

The actual filtering decisions can only be shown by the bench. It sweeps the length, error, promiscuous, broadcast, multicast and runt configuration bits against station, foreign unicast, broadcast and hashed multicast destinations, at lengths on both sides of 6 and 64 bytes. It then checks the transmitter on/off bins in both settings of the enable.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CFG_W        = 6;
  localparam int CFG_KEEP_ERR = 0;
  localparam int CFG_RUNT_OK  = 1;
  localparam int CFG_BCAST_OK = 2;
  localparam int CFG_MCAST_OK = 3;
  localparam int CFG_PROMISC  = 4;
  localparam int CFG_MONITOR  = 5;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // Reflected CRC-32 advanced by one byte, LSB of the byte first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ d[b];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_start,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  output logic [ADDR_BYTES*8-1:0] dest_addr,
  output logic [CNT_W-1:0]        byte_cnt,
  output logic                    addr_phase,
  output logic                    addr_done
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (frm_start)                          cnt_n = '0;
    else if (byte_valid && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_dest
    logic [7:0] dbyte_q;
    logic       ld_en;
    assign ld_en = byte_valid && !frm_start && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dbyte_q <= '0;
      else if (ld_en) dbyte_q <= byte_data;
    end
    assign dest_addr[g*8 +: 8] = dbyte_q;
  end

  assign byte_cnt   = cnt_q;
  assign addr_phase = (cnt_q < ADDR_END);
  assign addr_done  = !addr_phase;

  assert_count_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_start |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frm_start,
  input  logic                 upd_en,
  input  logic [7:0]           byte_data,
  output logic [HASH_BITS-1:0] hash_idx
);
  logic [31:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    if (frm_start)   crc_n = CRC_SEED;
    else if (upd_en) crc_n = crc_step_byte(crc_q, byte_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_n;
  end

  assign hash_idx = crc_q[31 -: HASH_BITS];

  assert_crc_reseed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (crc_q == CRC_SEED));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 12,
  parameter int HASH_BITS  = 6,
  parameter int MIN_LEN    = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CFG_W-1:0]          rx_cfg,
  input  logic [ADDR_BYTES*8-1:0]   station_addr,
  input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
  input  logic                      auto_tx_off_en,
  input  logic                      frm_start,
  input  logic                      frm_end,
  input  logic                      crc_err,
  input  logic                      align_err,
  input  logic [ADDR_BYTES*8-1:0]   dest_addr,
  input  logic [CNT_W-1:0]          byte_cnt,
  input  logic                      addr_done,
  input  logic [HASH_BITS-1:0]      hash_idx,
  output logic                      decision_valid,
  output logic                      frame_accept,
  output logic                      frame_group,
  output logic                      frame_store,
  output logic                      tx_enable
);
  localparam logic [CNT_W-1:0]     LEN_MIN = CNT_W'(MIN_LEN);
  localparam logic [HASH_BITS-1:0] BIN_ON  = {HASH_BITS{1'b1}};
  localparam logic [HASH_BITS-1:0] BIN_OFF = BIN_ON - 1'b1;

  logic is_group, is_bcast, is_station, addr_ok, len_ok, err_ok, acc_c;
  logic valid_q, valid_n, acc_q, acc_n, grp_q, grp_n, sto_q, sto_n, tx_q, tx_n;
  logic end_only;

  assign end_only   = frm_end && !frm_start;
  assign is_group   = dest_addr[0];
  assign is_bcast   = &dest_addr;
  assign is_station = (dest_addr == station_addr);

  always_comb begin
    if (is_bcast)      addr_ok = rx_cfg[CFG_BCAST_OK];
    else if (is_group) addr_ok = rx_cfg[CFG_MCAST_OK] && hash_tbl[hash_idx];
    else               addr_ok = rx_cfg[CFG_PROMISC] || is_station;
  end

  assign len_ok = addr_done && ((byte_cnt >= LEN_MIN) || rx_cfg[CFG_RUNT_OK]);
  assign err_ok = !(crc_err || align_err) || rx_cfg[CFG_KEEP_ERR];
  assign acc_c  = addr_ok && len_ok && err_ok;

  always_comb begin
    valid_n = valid_q;
    acc_n   = acc_q;
    grp_n   = grp_q;
    sto_n   = sto_q;
    if (frm_start) begin
      valid_n = 1'b0;
      acc_n   = 1'b0;
      sto_n   = 1'b0;
    end else if (frm_end) begin
      valid_n = 1'b1;
      acc_n   = acc_c;
      grp_n   = is_group;
      sto_n   = acc_c && !rx_cfg[CFG_MONITOR];
    end
  end

  always_comb begin
    tx_n = tx_q;
    if (end_only && auto_tx_off_en && addr_done && is_group && !is_bcast) begin
      if (hash_idx == BIN_OFF)     tx_n = 1'b0;
      else if (hash_idx == BIN_ON) tx_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      grp_q   <= 1'b0;
      sto_q   <= 1'b0;
      tx_q    <= 1'b1;
    end else begin
      if (frm_start || frm_end) begin
        valid_q <= valid_n;
        acc_q   <= acc_n;
        grp_q   <= grp_n;
        sto_q   <= sto_n;
      end
      if (end_only) tx_q <= tx_n;
    end
  end

  assign decision_valid = valid_q;
  assign frame_accept   = acc_q;
  assign frame_group    = grp_q;
  assign frame_store    = sto_q;
  assign tx_enable      = tx_q;

  assert_valid_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    end_only |=> valid_q);
  assert_clear_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !valid_q);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !frm_start && !frm_end) |=> ($stable(acc_q) && $stable(grp_q) && $stable(sto_q)));
  assert_store_needs_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sto_q |-> acc_q);
  assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !end_only |=> $stable(tx_q));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 12,
  parameter int HASH_BITS  = 6,
  parameter int MIN_LEN    = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CFG_W-1:0]          rx_cfg,
  input  logic [ADDR_BYTES*8-1:0]   station_addr,
  input  logic [(1<<HASH_BITS)-1:0] mcast_hash,
  input  logic                      auto_tx_off_en,
  input  logic                      frm_start,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic                      frm_end,
  input  logic                      frm_crc_err,
  input  logic                      frm_align_err,
  output logic                      decision_valid,
  output logic                      frame_accept,
  output logic                      frame_group,
  output logic                      frame_store,
  output logic                      tx_enable
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [ADDR_BYTES*8-1:0] dest_addr;
  logic [CNT_W-1:0]        byte_cnt;
  logic                    addr_phase, addr_done;
  logic [HASH_BITS-1:0]    hash_idx;

  rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(rst_int_n), .frm_start(frm_start),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .dest_addr(dest_addr), .byte_cnt(byte_cnt),
    .addr_phase(addr_phase), .addr_done(addr_done)
  );

  rxf_crc_hash #(.HASH_BITS(HASH_BITS)) u_hash (
    .clk(clk), .rst_n(rst_int_n), .frm_start(frm_start),
    .upd_en(byte_valid && addr_phase), .byte_data(byte_data),
    .hash_idx(hash_idx)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W),
               .HASH_BITS(HASH_BITS), .MIN_LEN(MIN_LEN)) u_decide (
    .clk(clk), .rst_n(rst_int_n), .rx_cfg(rx_cfg),
    .station_addr(station_addr), .hash_tbl(mcast_hash),
    .auto_tx_off_en(auto_tx_off_en), .frm_start(frm_start),
    .frm_end(frm_end), .crc_err(frm_crc_err), .align_err(frm_align_err),
    .dest_addr(dest_addr), .byte_cnt(byte_cnt), .addr_done(addr_done),
    .hash_idx(hash_idx), .decision_valid(decision_valid),
    .frame_accept(frame_accept), .frame_group(frame_group),
    .frame_store(frame_store), .tx_enable(tx_enable)
  );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  rx_cfg;
  logic [47:0] station_addr;
  logic [63:0] mcast_hash;
  logic        auto_tx_off_en, frm_start, byte_valid, frm_end, frm_crc_err, frm_align_err;
  logic [7:0]  byte_data;
  logic        decision_valid, frame_accept, frame_group, frame_store, tx_enable;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_cfg(rx_cfg), .station_addr(station_addr),
    .mcast_hash(mcast_hash), .auto_tx_off_en(auto_tx_off_en),
    .frm_start(frm_start), .byte_valid(byte_valid), .byte_data(byte_data),
    .frm_end(frm_end), .frm_crc_err(frm_crc_err), .frm_align_err(frm_align_err),
    .decision_valid(decision_valid), .frame_accept(frame_accept),
    .frame_group(frame_group), .frame_store(frame_store), .tx_enable(tx_enable)
  );

  localparam logic [47:0] STATION = 48'h55_44_33_22_11_02;
  localparam logic [47:0] OTHER   = 48'h56_44_33_22_11_02;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [63:0] TABLE   = 64'h3C5A_96E1_0F7B_D248;

  logic [47:0] mc_hit, mc_miss, mc_b62, mc_b63;

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp<190000", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference hash index: reflected CRC-32 over the six destination bytes.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ a[8*k+b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c[31:26];
  endfunction

  task automatic send_frame(input logic [47:0] dst, input int len,
                            input logic ce, input logic ae);
    @(negedge clk) frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      byte_valid = 1'b1;
      byte_data  = (i < 6) ? dst[8*i +: 8] : 8'(i);
      @(negedge clk);
    end
    byte_valid    = 1'b0;
    frm_end       = 1'b1;
    frm_crc_err   = ce;
    frm_align_err = ae;
    @(negedge clk);
    frm_end       = 1'b0;
    frm_crc_err   = 1'b0;
    frm_align_err = 1'b0;
  endtask

  function automatic string acc_tag(input int kind, input int len, input int e);
    if (len < 64) return "R3";
    if (e != 0)   return "R4";
    if (kind <= 1) return "R5";
    if (kind == 2) return "R6";
    return "R7";
  endfunction

  initial begin
    bit f_hit, f_miss, f62, f63;
    logic [47:0] cand;
    logic [5:0]  ix;
    logic [47:0] dsts[5];
    int          lens[3];
    logic        exp_acc, addr_ok;

    rst_n = 1'b0;
    rx_cfg = '0; station_addr = STATION; mcast_hash = TABLE;
    auto_tx_off_en = 1'b0; frm_start = 1'b0; byte_valid = 1'b0; byte_data = '0;
    frm_end = 1'b0; frm_crc_err = 1'b0; frm_align_err = 1'b0;

    f_hit = 0; f_miss = 0; f62 = 0; f63 = 0;
    mc_hit = '0; mc_miss = '0; mc_b62 = '0; mc_b63 = '0;
    for (int j = 0; j < 65536; j++) begin
      cand = {j[15:8], j[7:0], 8'h10, 8'h5e, 8'h00, 8'h01};
      ix = ref_idx(cand);
      if (ix == 6'd62) begin
        if (!f62) begin mc_b62 = cand; f62 = 1; end
      end else if (ix == 6'd63) begin
        if (!f63) begin mc_b63 = cand; f63 = 1; end
      end else if (TABLE[ix]) begin
        if (!f_hit) begin mc_hit = cand; f_hit = 1; end
      end else if (!f_miss) begin
        mc_miss = cand; f_miss = 1;
      end
    end
    chk("R7 search", {28'd0, f_hit, f_miss, f62, f63}, 32'hF);

    repeat (3) @(negedge clk);
    chk("R1 tx_enable in reset", {31'd0, tx_enable}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 decision_valid", {31'd0, decision_valid}, 32'd0);
    chk("R1 frame_accept", {31'd0, frame_accept}, 32'd0);
    chk("R1 tx_enable", {31'd0, tx_enable}, 32'd1);

    dsts[0] = STATION; dsts[1] = OTHER; dsts[2] = BCAST;
    dsts[3] = mc_hit;  dsts[4] = mc_miss;
    lens[0] = 4; lens[1] = 63; lens[2] = 64;

    // Sweep: config bits 0..4, destination kind, length, error kind.
    for (int c = 0; c < 32; c++)
      for (int kind = 0; kind < 5; kind++)
        for (int li = 0; li < 3; li++)
          for (int e = 0; e < 3; e++) begin
            logic mon;
            mon = 1'((c + kind + li + e) % 2);
            rx_cfg = {mon, 5'(c)};
            send_frame(dsts[kind], lens[li], e == 1, e == 2);
            case (kind)
              0: addr_ok = 1'b1;
              1: addr_ok = c[4];
              2: addr_ok = c[2];
              3: addr_ok = c[3];
              default: addr_ok = 1'b0;
            endcase
            exp_acc = addr_ok
                      && (lens[li] >= 6) && ((lens[li] >= 64) || c[1])
                      && ((e == 0) || c[0]);
            chk("R2 valid after end", {31'd0, decision_valid}, 32'd1);
            chk(acc_tag(kind, lens[li], e), {31'd0, frame_accept}, {31'd0, exp_acc});
            chk("R9 store", {31'd0, frame_store}, {31'd0, exp_acc && !mon});
            if (exp_acc)
              chk("R8 group", {31'd0, frame_group}, {31'd0, kind >= 2});
            chk("R10 no tx change when disabled", {31'd0, tx_enable}, 32'd1);
          end

    // R2: hold until the next start, then clear.
    rx_cfg = 6'b000100;
    send_frame(BCAST, 70, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R2 hold valid", {31'd0, decision_valid}, 32'd1);
    chk("R2 hold accept", {31'd0, frame_accept}, 32'd1);
    chk("R2 hold group", {31'd0, frame_group}, 32'd1);
    frm_start = 1'b1;
    @(negedge clk) frm_start = 1'b0;
    chk("R2 clear after start", {31'd0, decision_valid}, 32'd0);

    // R10: remote transmitter control.
    rx_cfg = 6'b001000;
    auto_tx_off_en = 1'b0;
    send_frame(mc_b62, 64, 1'b0, 1'b0);
    chk("R10 bin62 ignored when disabled", {31'd0, tx_enable}, 32'd1);
    auto_tx_off_en = 1'b1;
    send_frame(mc_b62, 64, 1'b0, 1'b0);
    chk("R10 bin62 turns off", {31'd0, tx_enable}, 32'd0);
    send_frame(BCAST, 64, 1'b0, 1'b0);
    chk("R10 broadcast no effect", {31'd0, tx_enable}, 32'd0);
    send_frame(mc_hit, 64, 1'b0, 1'b0);
    chk("R10 other bin no effect", {31'd0, tx_enable}, 32'd0);
    send_frame(mc_b63, 64, 1'b0, 1'b0);
    chk("R10 bin63 turns on", {31'd0, tx_enable}, 32'd1);
    send_frame(mc_b62, 20, 1'b1, 1'b0);
    chk("R10 bin62 with error still off", {31'd0, tx_enable}, 32'd0);
    auto_tx_off_en = 1'b0;
    send_frame(mc_b63, 64, 1'b0, 1'b0);
    chk("R10 bin63 ignored when disabled", {31'd0, tx_enable}, 32'd0);

    finished = 1;
    report();
  end
endmodule